// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is an SPI target that gives an external host read and write access to 32-bit registers inside a device. Register space is organised in three levels: a 3-bit block, a 4-bit subblock and an 8-bit register address. Each chip-select window carries exactly one access. The first byte holds the block, the direction and the subblock. The second byte holds the register address. A write then carries four data bytes. A read carries two padding bytes, and the target then returns four data bytes.

SCLK, MOSI and CS_N are brought into the system clock domain through synchronisers, and all edge detection takes place there. On the register side the bridge drives a simple parallel bus: block, subblock and register fields, a one-cycle write strobe with write data, and a one-cycle read strobe. The responder on that bus returns its data with one cycle of latency: it registers its answer on the edge that sees the read strobe, and the bridge takes `reg_rdata` on the following edge. A parameterised validity rule marks some block/subblock pairs as illegal. A write to an illegal pair is dropped, and a read from one returns zero without a strobe.

Top module: `spi_regbus_bridge`

## Requirements
- R1: SPI mode 0: MOSI is sampled on rising SCLK and MISO changes only after falling SCLK, with 8-bit words and the most significant bit first.
- R2: In the first byte, bits [7:5] are the block, bit [4] is the direction (0 = read, 1 = write) and bits [3:0] are the subblock. The second byte is the register address. These fields appear on `reg_block`, `reg_sub` and `reg_addr`.
- R3: A write issues exactly one single-cycle `reg_wr` after the 48th bit. `reg_wdata` holds the four data bytes, with the first byte received in bits [31:24].
- R4: A read issues exactly one single-cycle `reg_rd` after the 16th bit, before any padding bit is shifted. `reg_rdata` is taken on the clock edge after the edge that sees `reg_rd`.
- R5: Read data appears on MISO in bytes 5 to 8 of the selection (bits 32 to 63), most significant bit first, after two padding bytes.
- R6: MISO is 0 during the command bytes, during the padding bytes, during every write and while CS_N is high.
- R7: If CS_N rises before all 48 bits of a write have arrived, no `reg_wr` is issued.
- R8: A CS_N deassertion clears the bit and byte position, so the next selection starts with a new command byte, even after a partial byte.
- R9: A block/subblock pair is legal when bit `block` of `VALID_BLOCKS` is set and the subblock is below `SUB_COUNT`. With the defaults, blocks 0, 1, 2, 3 and 5 with subblocks 0 to 7 are legal. An illegal write issues no `reg_wr`. An illegal read issues no `reg_rd` and returns zero.
- R10: Bits clocked beyond the end of an access produce no further strobe and do not change the data already transferred.
- R11: During reset all outputs are 0, and `reg_rd` and `reg_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from host |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low target select |
| miso | output | 1 | Serial data to host |
| reg_block | output | 3 | Block field of the current access |
| reg_sub | output | 4 | Subblock field of the current access |
| reg_addr | output | 8 | Register address of the current access |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 32 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 32 | Read data from the responder, one cycle after `reg_rd` |

## Verification
The bench reads every one of the 128 block/subblock pairs and writes every block at subblocks 0, 7, 8 and 15. This hits both edges of the legality rule, so a wrong mask or bound would strobe an illegal register or silence a legal one. Every MISO bit of the command and padding bytes is compared against zero. A bridge that shifted the answer a byte early or late, or reversed its bit order, would therefore fail on data and on quiet bits alike. The bench also cuts writes short after two data bytes and one bit before the end, and cuts a selection after three bits. A bridge that kept its bit position across CS_N, or wrote on partial data, would corrupt or spuriously trigger the next access. Trailing bytes after a full access check that a wrap-around counter cannot produce a second strobe.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BLK_W  = 3;
  localparam int unsigned SUB_W  = 4;

  // First command byte: block [7:5], direction [4], subblock [3:0]
  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic             wr;
    logic [SUB_W-1:0] sub;
  } cmd_t;

  // Legality of a block/subblock pair
  function automatic logic addr_ok(input logic [BLK_W-1:0]      blk,
                                   input logic [SUB_W-1:0]      sub,
                                   input logic [(1<<BLK_W)-1:0] blk_mask,
                                   input int unsigned           sub_count);
    return blk_mask[blk] && (32'(sub) < sub_count);
  endfunction

  // Which read-data bit goes out for a given bit position
  function automatic int unsigned tx_bit_index(input int unsigned cnt,
                                               input int unsigned end_bit);
    return end_bit - 1 - cnt;
  endfunction

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int unsigned     WIDTH   = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= (chain << 1) | STAGES'(d[i]);
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sbr_rx.sv
module sbr_rx
  import sbr_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned RD_STROBE_BIT = 16,
  parameter int unsigned WR_END        = 48,
  parameter int unsigned RD_END        = 64,
  parameter int unsigned CNT_W         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output cmd_t              cmd_q,
  output logic [BYTE_W-1:0] reg_addr_q,
  output logic [DATA_W-1:0] shift_q,
  output logic              fall,
  output logic              reg_done,
  output logic              data_done
);

  logic sclk_d;
  wire  sel  = ~cs_n_s;
  wire  rise = sel & sclk_s & ~sclk_d;
  assign fall = sel & ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      bit_cnt    <= '0;
      shift_q    <= '0;
      cmd_q      <= '0;
      reg_addr_q <= '0;
      reg_done   <= 1'b0;
      data_done  <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      reg_done  <= 1'b0;
      data_done <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shift_q <= {shift_q[DATA_W-2:0], mosi_s};
        if (bit_cnt != CNT_W'(RD_END)) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W-1))
          cmd_q <= cmd_t'({shift_q[BYTE_W-2:0], mosi_s});
        if (bit_cnt == CNT_W'(RD_STROBE_BIT-1)) begin
          reg_addr_q <= {shift_q[BYTE_W-2:0], mosi_s};
          reg_done   <= 1'b1;
        end
        if (bit_cnt == CNT_W'(WR_END-1)) data_done <= 1'b1;
      end
    end
  end

  // R8: a deselect clears the position by the next cycle
  assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == '0));

  // R10: the position saturates at the end of the longest access
  assert_cnt_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(RD_END));

  // R1: a sampled bit needs a rising edge while selected
  assert_shift_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != $past(bit_cnt) && bit_cnt != '0) |-> ($past(sclk_s) && !$past(sclk_d)));

endmodule

// File: rtl/sbr_tx.sv
module sbr_tx #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned RD_DATA_START = 32,
  parameter int unsigned RD_END        = 64,
  parameter int unsigned CNT_W         = 7,
  localparam int unsigned IDX_W        = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              fall,
  input  logic              rd_mode,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [DATA_W-1:0] rdata,
  output logic              miso
);

  wire [IDX_W-1:0] idx = IDX_W'(sbr_pkg::tx_bit_index(32'(bit_cnt), RD_END));
  wire in_window = rd_mode && (bit_cnt >= CNT_W'(RD_DATA_START)) &&
                   (bit_cnt < CNT_W'(RD_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      miso <= 1'b0;
    else if (cs_n_s) miso <= 1'b0;
    else if (fall)   miso <= in_window ? rdata[idx] : 1'b0;
  end

  // R6: MISO is high only inside the read-data bytes
  assert_miso_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miso |-> (rd_mode && bit_cnt >= CNT_W'(RD_DATA_START)));

  // R1: MISO changes only after a falling edge or a deselect
  assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(fall) || $past(cs_n_s)));

endmodule

// File: rtl/spi_regbus_bridge.sv
module spi_regbus_bridge
  import sbr_pkg::*;
#(
  parameter int unsigned  SYNC_STAGES  = 2,
  parameter logic [7:0]   VALID_BLOCKS = 8'h2F,
  parameter int unsigned  SUB_COUNT    = 8,
  parameter int unsigned  PAD_BYTES    = 2,
  parameter int unsigned  DATA_BYTES   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       mosi,
  input  logic                       cs_n,
  output logic                       miso,
  output logic [2:0]                 reg_block,
  output logic [3:0]                 reg_sub,
  output logic [7:0]                 reg_addr,
  output logic                       reg_wr,
  output logic [DATA_BYTES*8-1:0]    reg_wdata,
  output logic                       reg_rd,
  input  logic [DATA_BYTES*8-1:0]    reg_rdata
);

  localparam int unsigned DATA_W        = DATA_BYTES * BYTE_W;
  localparam int unsigned RD_STROBE_BIT = 2 * BYTE_W;
  localparam int unsigned WR_END        = RD_STROBE_BIT + DATA_W;
  localparam int unsigned RD_DATA_START = RD_STROBE_BIT + PAD_BYTES * BYTE_W;
  localparam int unsigned RD_END        = RD_DATA_START + DATA_W;
  localparam int unsigned CNT_W         = $clog2(RD_END + 1);

  logic              sclk_s, mosi_s, cs_n_s;
  logic [CNT_W-1:0]  bit_cnt;
  cmd_t              cmd_q;
  logic [BYTE_W-1:0] reg_addr_q;
  logic [DATA_W-1:0] shift_q;
  logic              fall, reg_done, data_done;
  logic              rd_pend;
  logic [DATA_W-1:0] rdata_q;

  sbr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({sclk, mosi, cs_n}),
    .q   ({sclk_s, mosi_s, cs_n_s})
  );

  sbr_rx #(
    .DATA_W(DATA_W), .RD_STROBE_BIT(RD_STROBE_BIT), .WR_END(WR_END),
    .RD_END(RD_END), .CNT_W(CNT_W)
  ) u_rx (
    .clk (clk), .rst_n (rst_n),
    .sclk_s (sclk_s), .mosi_s (mosi_s), .cs_n_s (cs_n_s),
    .bit_cnt (bit_cnt), .cmd_q (cmd_q), .reg_addr_q (reg_addr_q),
    .shift_q (shift_q), .fall (fall),
    .reg_done (reg_done), .data_done (data_done)
  );

  sbr_tx #(
    .DATA_W(DATA_W), .RD_DATA_START(RD_DATA_START), .RD_END(RD_END), .CNT_W(CNT_W)
  ) u_tx (
    .clk (clk), .rst_n (rst_n), .cs_n_s (cs_n_s), .fall (fall),
    .rd_mode (~cmd_q.wr), .bit_cnt (bit_cnt), .rdata (rdata_q), .miso (miso)
  );

  // Decoded events brought out as named wires
  wire addr_valid = addr_ok(cmd_q.blk, cmd_q.sub, VALID_BLOCKS, SUB_COUNT);
  wire rd_fire    = reg_done  & ~cmd_q.wr &  addr_valid;
  wire rd_void    = reg_done  & ~cmd_q.wr & ~addr_valid;
  wire wr_fire    = data_done &  cmd_q.wr &  addr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      rd_pend   <= 1'b0;
      reg_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      reg_rd  <= rd_fire;
      rd_pend <= reg_rd;
      reg_wr  <= wr_fire;
      if (wr_fire)      reg_wdata <= shift_q;
      if (rd_void)      rdata_q   <= '0;
      else if (rd_pend) rdata_q   <= reg_rdata;
    end
  end

  assign reg_block = cmd_q.blk;
  assign reg_sub   = cmd_q.sub;
  assign reg_addr  = reg_addr_q;

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_rd_after_reg_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> ($past(bit_cnt) == CNT_W'(RD_STROBE_BIT)));

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_wr_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(bit_cnt) == CNT_W'(WR_END)));

  assert_wr_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> addr_ok(reg_block, reg_sub, VALID_BLOCKS, SUB_COUNT));

  assert_rd_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> addr_ok(reg_block, reg_sub, VALID_BLOCKS, SUB_COUNT));

endmodule

// File: tb/spi_regbus_bridge_test.sv
module spi_regbus_bridge_test;

  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        cs_n = 1'b1;
  logic        miso;
  logic [2:0]  reg_block;
  logic [3:0]  reg_sub;
  logic [7:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [31:0] last_wdata;
  logic [14:0] last_wr_addr, last_rd_addr;

  always #10 clk = ~clk;

  spi_regbus_bridge uut (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .mosi (mosi), .cs_n (cs_n),
    .miso (miso), .reg_block (reg_block), .reg_sub (reg_sub), .reg_addr (reg_addr),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rd (reg_rd), .reg_rdata (reg_rdata)
  );

  function automatic logic [31:0] pat(input logic [2:0] b, input logic [3:0] s,
                                      input logic [7:0] r);
    return {r, r ^ 8'h5A, b, 1'b1, s, ~r};
  endfunction

  function automatic bit legal(input logic [2:0] b, input logic [3:0] s);
    return (((8'h2F >> b) & 8'h01) == 8'h01) && (s < 4'd8);
  endfunction

  // Responder: one cycle latency, garbage when not asked
  always @(posedge clk) begin
    if (reg_rd) begin
      reg_rdata    <= pat(reg_block, reg_sub, reg_addr);
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= {reg_block, reg_sub, reg_addr};
    end else begin
      reg_rdata <= 32'hDEAD_BEEF;
    end
    if (reg_wr) begin
      wr_cnt       <= wr_cnt + 1;
      last_wdata   <= reg_wdata;
      last_wr_addr <= {reg_block, reg_sub, reg_addr};
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_begin;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_end;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] b, input logic [3:0] s, input logic [7:0] r,
                         input int extra, output logic [31:0] lead, output logic [31:0] data);
    logic [7:0] rx;
    sel_begin();
    spi_bits({b, 1'b0, s}, 8, rx); lead[31:24] = rx;
    spi_bits(r, 8, rx);            lead[23:16] = rx;
    spi_bits(8'h00, 8, rx);        lead[15:8]  = rx;
    spi_bits(8'h00, 8, rx);        lead[7:0]   = rx;
    for (int k = 3; k >= 0; k--) begin
      spi_bits(8'h00, 8, rx);
      data[k*8 +: 8] = rx;
    end
    for (int k = 0; k < extra; k++) spi_bits(8'hFF, 8, rx);
    sel_end();
  endtask

  task automatic do_write(input logic [2:0] b, input logic [3:0] s, input logic [7:0] r,
                          input logic [31:0] d, input int nbits, output logic [47:0] seen);
    logic [7:0] rx;
    logic [7:0] bytes [8];
    int left;
    bytes[0] = {b, 1'b1, s}; bytes[1] = r;
    bytes[2] = d[31:24]; bytes[3] = d[23:16]; bytes[4] = d[15:8]; bytes[5] = d[7:0];
    bytes[6] = 8'hA5; bytes[7] = 8'h3C;
    seen = '0;
    left = nbits;
    sel_begin();
    for (int k = 0; k < 8 && left > 0; k++) begin
      spi_bits(bytes[k], (left >= 8) ? 8 : left, rx);
      if (k < 6) seen[(5-k)*8 +: 8] = rx;
      left -= 8;
    end
    sel_end();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] lead, data, d;
    logic [47:0] seen;
    logic [3:0]  s;
    logic [7:0]  r;
    int          prev;

    repeat (5) @(negedge clk);
    check("R11 reset outputs", {miso, reg_wr, reg_rd, reg_block, reg_sub, reg_addr},
          '0);
    check("R11 reset wdata", reg_wdata, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3/R9/R6/R1: write sweep across all blocks, subblock edges
    for (int b = 0; b < 8; b++) begin
      for (int si = 0; si < 4; si++) begin
        s = (si == 0) ? 4'd0 : (si == 1) ? 4'd7 : (si == 2) ? 4'd8 : 4'd15;
        r = 8'(b * 37 + si * 11);
        d = (32'(b) * 32'h0101_0101) ^ (32'(s) * 32'h1111_0000) ^ 32'(r) ^ 32'hC3A5_0F00;
        prev = wr_cnt;
        do_write(3'(b), s, r, d, 48, seen);
        check("R6 miso quiet in write", seen, '0);
        if (legal(3'(b), s)) begin
          check("R3 write count", wr_cnt, prev + 1);
          check("R2 write fields", last_wr_addr, {3'(b), s, r});
          check("R1 R3 write data msb first", last_wdata, d);
        end else begin
          check("R9 illegal write dropped", wr_cnt, prev);
        end
      end
    end

    // R4/R5/R9/R6: read sweep over every block/subblock pair
    for (int b = 0; b < 8; b++) begin
      for (int si = 0; si < 16; si++) begin
        s = 4'(si);
        r = 8'(b * 29 + si * 7 + 3);
        prev = rd_cnt;
        do_read(3'(b), s, r, 0, lead, data);
        check("R6 miso quiet in command/pad", lead, '0);
        if (legal(3'(b), s)) begin
          check("R4 read strobe count", rd_cnt, prev + 1);
          check("R2 read fields", last_rd_addr, {3'(b), s, r});
          check("R5 read data", data, pat(3'(b), s, r));
        end else begin
          check("R9 illegal read no strobe", rd_cnt, prev);
          check("R9 illegal read zero", data, '0);
        end
      end
    end

    // R7: writes cut short
    prev = wr_cnt;
    do_write(3'd1, 4'd2, 8'h44, 32'h1234_5678, 32, seen);
    check("R7 cut after two data bytes", wr_cnt, prev);
    do_write(3'd1, 4'd2, 8'h44, 32'h1234_5678, 47, seen);
    check("R7 cut one bit early", wr_cnt, prev);

    // R8: partial byte, then a fresh access
    sel_begin();
    spi_bits(8'hFF, 3, r);
    sel_end();
    prev = rd_cnt;
    do_read(3'd5, 4'd6, 8'h9C, 0, lead, data);
    check("R8 fresh read after partial", data, pat(3'd5, 4'd6, 8'h9C));
    check("R8 fresh read strobe", rd_cnt, prev + 1);
    prev = wr_cnt;
    do_write(3'd2, 4'd3, 8'h7E, 32'hFACE_0123, 48, seen);
    check("R8 fresh write after cut", last_wdata, 32'hFACE_0123);
    check("R8 fresh write count", wr_cnt, prev + 1);

    // R10: trailing bits
    prev = wr_cnt;
    do_write(3'd0, 4'd1, 8'h10, 32'h0BAD_F00D, 64, seen);
    check("R10 write trailing count", wr_cnt, prev + 1);
    check("R10 write trailing data", last_wdata, 32'h0BAD_F00D);
    prev = rd_cnt;
    do_read(3'd3, 4'd4, 8'h21, 3, lead, data);
    check("R10 read trailing count", rd_cnt, prev + 1);
    check("R10 read trailing data", data, pat(3'd3, 4'd4, 8'h21));

    check("R6 miso idle", miso, 1'b0);

    report();
    $finish;
  end

endmodule